// File: doc/BRIEF.md
# Interval Timer with Halt Gating and Watchdog Expiry

This block is a free-running interval counter that a processor controls through three registers: the running count, a control word and the terminal value. The count advances by one on every enabled clock edge. When it has reached the terminal value, the next enabled edge returns it to zero and sets a sticky expiry flag. The flag drives a level interrupt request when the interrupt enable bit is set. A period of N cycles is set by writing N-1 as the terminal value.

Counting can be made to pause while the processor is halted, so that a debugger stop does not consume the interval. In watchdog mode each expiry also raises a single-cycle reset request beside the flag. Software clears the flag by writing the control word with the flag bit at zero. An expiry that lands on the same edge as such a clearing write is kept.

Top module: `aux_interval_timer`

## Requirements
- R1: While and after reset, the count reads 0, the control word reads 0, the terminal value reads all ones, and `irq_o` and `wdt_rst_o` are low.
- R2: Address 0 selects the count, 1 the control word, 2 the terminal value, and 3 reads as zero. Read data follows `reg_addr` in the same cycle. Control bits: bit 0 is interrupt enable, bit 1 is halt gating, bit 2 is watchdog mode, bit 3 is the expiry flag, and bits above 3 ignore writes and read as 0.
- R3: With counting enabled the count rises by one per clock edge. On the edge after it equals the terminal value it becomes 0 and the expiry flag is set, so the period is terminal value + 1 cycles.
- R4: A write to address 2 loads the terminal value and sets the count to 0 on the same edge.
- R5: A write to address 0 loads the count with the written value and replaces that edge's increment.
- R6: With control bit 1 set and `halt_i` high, the count holds. With bit 1 clear, `halt_i` has no effect.
- R7: A control write with bit 3 at 0 clears the expiry flag. A control write with bit 3 at 1 leaves the flag unchanged, so software cannot set it.
- R8: When an expiry and a flag-clearing control write fall on the same edge, the flag ends set.
- R9: `irq_o` is high exactly while the expiry flag and control bit 0 are both set. With bit 0 clear the flag still sets and reads back.
- R10: An expiry while control bit 2 is set drives `wdt_rst_o` high for exactly the one cycle after the expiry edge. Without bit 2 it stays low.
- R11: Writing 0 to the control word drops `irq_o`, and later expiries set the flag without raising `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Processor halted indication |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt request |
| wdt_rst_o | output | 1 | Single-cycle watchdog reset request |

## Verification
Every register write takes effect on the clock edge that samples it, so the bench drives at the falling edge and reads the new state at the next falling edge. Read data is combinational, so reads take no cycle. After the terminal value is written the count reads 0 at once, it reads the terminal value after that many further edges, and the expiry flag, `irq_o` and `wdt_rst_o` become visible one edge later. The bench counts exactly those edges before each sample. The race case places a clearing control write on the very edge where the count equals the terminal value. The halt case checks that the edge of the write that turns gating off still holds the count.

// File: rtl/ait_pkg.sv
package ait_pkg;
   localparam int AIT_ADDR_W = 2;

   typedef enum logic [AIT_ADDR_W-1:0] {
      SEL_COUNT = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_LIMIT = 2'd2,
      SEL_NONE  = 2'd3
   } ait_sel_e;

   // Control word bit positions (software decodes these)
   localparam int CB_IE   = 0;
   localparam int CB_GATE = 1;
   localparam int CB_WDOG = 2;
   localparam int CB_PEND = 3;
   localparam int CB_USED = 4;

   typedef struct packed {
      logic pend;
      logic wdog;
      logic gate;
      logic ie;
   } ait_ctl_t;
endpackage

// File: rtl/ait_decode.sv
module ait_decode
   import ait_pkg::*;
(
   input  logic [AIT_ADDR_W-1:0] addr,
   input  logic                  we,
   output logic                  wr_count,
   output logic                  wr_ctrl,
   output logic                  wr_limit
);
   always_comb begin
      wr_count = 1'b0;
      wr_ctrl  = 1'b0;
      wr_limit = 1'b0;
      if (we) begin
         unique case (addr)
            SEL_COUNT: wr_count = 1'b1;
            SEL_CTRL:  wr_ctrl  = 1'b1;
            SEL_LIMIT: wr_limit = 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/ait_counter.sv
module ait_counter #(
   parameter int              WIDTH       = 32,
   parameter logic [WIDTH-1:0] RESET_LIMIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             wr_count,
   input  logic             wr_limit,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] count_q,
   output logic [WIDTH-1:0] limit_q,
   output logic             wrap
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   // Expiry only on an edge that is not overridden by a software load
   assign wrap = count_en && !wr_count && !wr_limit && (count_q == limit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         limit_q <= RESET_LIMIT;
      end else if (wr_limit) begin
         limit_q <= wdata;
         count_q <= '0;
      end else if (wr_count) begin
         count_q <= wdata;
      end else if (count_en) begin
         count_q <= wrap ? '0 : count_q + ONE;
      end
   end
endmodule

// File: rtl/ait_control.sv
module ait_control
   import ait_pkg::*;
#(
   parameter bit HAS_WDOG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_ctrl,
   input  logic [CB_USED-1:0] wbits,
   input  logic           wrap,
   output ait_ctl_t       ctl,
   output logic           irq,
   output logic           wdt_rst
);
   logic ie_q, gate_q, pend_q;
   logic pend_d;

   // Software may only clear the flag; an expiry on the same edge wins
   always_comb begin
      pend_d = pend_q;
      if (wr_ctrl && !wbits[CB_PEND]) pend_d = 1'b0;
      if (wrap) pend_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         gate_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         if (wr_ctrl) begin
            ie_q   <= wbits[CB_IE];
            gate_q <= wbits[CB_GATE];
         end
      end
   end

   generate
      if (HAS_WDOG) begin : g_wdog
         logic wd_q, rst_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wd_q  <= 1'b0;
               rst_q <= 1'b0;
            end else begin
               rst_q <= wrap && wd_q;
               if (wr_ctrl) wd_q <= wbits[CB_WDOG];
            end
         end
         assign ctl.wdog = wd_q;
         assign wdt_rst  = rst_q;
      end else begin : g_no_wdog
         logic unused_wdog_bit;
         assign unused_wdog_bit = wbits[CB_WDOG];
         assign ctl.wdog = 1'b0;
         assign wdt_rst  = 1'b0;
      end
   endgenerate

   assign ctl.ie   = ie_q;
   assign ctl.gate = gate_q;
   assign ctl.pend = pend_q;
   assign irq      = pend_q & ie_q;
endmodule

// File: rtl/ait_readback.sv
module ait_readback
   import ait_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [AIT_ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]      count_q,
   input  logic [WIDTH-1:0]      limit_q,
   input  ait_ctl_t              ctl,
   output logic [WIDTH-1:0]      rdata
);
   localparam int PAD = WIDTH - CB_USED;

   logic [WIDTH-1:0] ctl_word;
   assign ctl_word = {{PAD{1'b0}}, ctl};

   always_comb begin
      unique case (addr)
         SEL_COUNT: rdata = count_q;
         SEL_CTRL:  rdata = ctl_word;
         SEL_LIMIT: rdata = limit_q;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/aux_interval_timer.sv
module aux_interval_timer
   import ait_pkg::*;
#(
   parameter int               WIDTH       = 32,
   parameter logic [WIDTH-1:0] RESET_LIMIT = '1,
   parameter bit               HAS_WDOG    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  halt_i,
   input  logic [AIT_ADDR_W-1:0] reg_addr,
   input  logic                  reg_we,
   input  logic [WIDTH-1:0]      reg_wdata,
   output logic [WIDTH-1:0]      reg_rdata,
   output logic                  irq_o,
   output logic                  wdt_rst_o
);
   generate
      if (WIDTH < CB_USED) begin : g_bad_width
         $error("aux_interval_timer: WIDTH must hold the control bits");
      end
   endgenerate

   logic             wr_count, wr_ctrl, wr_limit;
   logic             count_en, wrap;
   logic [WIDTH-1:0] count_q, limit_q;
   ait_ctl_t         ctl;

   ait_decode u_decode (
      .addr     (reg_addr),
      .we       (reg_we),
      .wr_count (wr_count),
      .wr_ctrl  (wr_ctrl),
      .wr_limit (wr_limit)
   );

   // Halt freezes the count only when gating is selected
   assign count_en = !(ctl.gate && halt_i);

   ait_counter #(.WIDTH(WIDTH), .RESET_LIMIT(RESET_LIMIT)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (count_en),
      .wr_count (wr_count),
      .wr_limit (wr_limit),
      .wdata    (reg_wdata),
      .count_q  (count_q),
      .limit_q  (limit_q),
      .wrap     (wrap)
   );

   ait_control #(.HAS_WDOG(HAS_WDOG)) u_control (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wbits   (reg_wdata[CB_USED-1:0]),
      .wrap    (wrap),
      .ctl     (ctl),
      .irq     (irq_o),
      .wdt_rst (wdt_rst_o)
   );

   ait_readback #(.WIDTH(WIDTH)) u_readback (
      .addr    (reg_addr),
      .count_q (count_q),
      .limit_q (limit_q),
      .ctl     (ctl),
      .rdata   (reg_rdata)
   );
endmodule

// File: rtl/ait_checker.sv
module ait_checker
   import ait_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  halt_i,
   input logic [AIT_ADDR_W-1:0] reg_addr,
   input logic                  reg_we,
   input logic [WIDTH-1:0]      reg_wdata,
   input logic                  irq_o,
   input logic                  wdt_rst_o,
   input logic [WIDTH-1:0]      count_q,
   input logic [WIDTH-1:0]      limit_q,
   input ait_ctl_t              ctl
);
   logic sw_load, run, at_end;
   assign sw_load = reg_we && (reg_addr == SEL_COUNT || reg_addr == SEL_LIMIT);
   assign run     = !(ctl.gate && halt_i);
   assign at_end  = !sw_load && run && (count_q == limit_q);

   AST_LIMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == SEL_LIMIT |=> count_q == '0); // R4

   AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == SEL_COUNT |=> count_q == $past(reg_wdata)); // R5

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_load && ctl.gate && halt_i |=> $stable(count_q)); // R6

   AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      at_end |=> count_q == '0 && ctl.pend); // R3 R8

   AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.pend) |-> $past(at_end)); // R7

   AST_WDT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |=> !wdt_rst_o); // R10

   AST_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == SEL_CTRL && reg_wdata[CB_USED-1:0] == '0 |=> !irq_o); // R11
endmodule

bind aux_interval_timer ait_checker #(.WIDTH(WIDTH)) u_ait_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .halt_i    (halt_i),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .irq_o     (irq_o),
   .wdt_rst_o (wdt_rst_o),
   .count_q   (count_q),
   .limit_q   (limit_q),
   .ctl       (ctl)
);

// File: tb/test_aux_interval_timer.sv
`timescale 1ns/1ps
module test_aux_interval_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt_i = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, wdt_rst_o;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   aux_interval_timer i_aux_interval_timer (
      .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
   );

   localparam logic [1:0] A_CNT = 2'd0, A_CTL = 2'd1, A_LIM = 2'd2, A_NONE = 2'd3;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      @(negedge clk);
      rd(A_CNT, v); chk("R1 count", v, 32'h0);
      rd(A_CTL, v); chk("R1 control", v, 32'h0);
      rd(A_LIM, v); chk("R1 limit", v, 32'hFFFF_FFFF);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      chk("R1 wdt", {31'b0, wdt_rst_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_regmap;
      logic [31:0] v;
      rd(A_NONE, v); chk("R2 unused address", v, 32'h0);
      wr(A_CTL, 32'hFFFF_FFF3);
      rd(A_CTL, v); chk("R2 control upper bits", v, 32'h3);
   endtask

   task automatic t_period;
      logic [31:0] v;
      wr(A_LIM, 32'd4);
      rd(A_CNT, v); chk("R4 limit write zeroes count", v, 32'd0);
      rd(A_LIM, v); chk("R4 limit loaded", v, 32'd4);
      repeat (4) @(negedge clk);
      rd(A_CNT, v); chk("R3 count at terminal", v, 32'd4);
      chk("R3 no expiry yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rd(A_CNT, v); chk("R3 wrapped to zero", v, 32'd0);
      chk("R9 irq on expiry", {31'b0, irq_o}, 32'h1);
      chk("R10 no wdt without mode", {31'b0, wdt_rst_o}, 32'h0);
      rd(A_CTL, v); chk("R3 flag set", v, 32'hB);
   endtask

   task automatic t_flag_writes;
      logic [31:0] v;
      wr(A_CTL, 32'hB);
      rd(A_CTL, v); chk("R7 bit3=1 keeps flag", v, 32'hB);
      wr(A_CTL, 32'h3);
      rd(A_CTL, v); chk("R7 bit3=0 clears flag", v, 32'h3);
      chk("R7 irq dropped", {31'b0, irq_o}, 32'h0);
      wr(A_CTL, 32'hB);
      rd(A_CTL, v); chk("R7 bit3=1 cannot set", v, 32'h3);
   endtask

   task automatic t_race;
      logic [31:0] v;
      wr(A_LIM, 32'd4);
      repeat (5) @(negedge clk);
      repeat (4) @(negedge clk);
      rd(A_CNT, v); chk("R8 count at terminal", v, 32'd4);
      wr(A_CTL, 32'h3);
      rd(A_CTL, v); chk("R8 expiry beats clear", v, 32'hB);
      chk("R8 irq stays", {31'b0, irq_o}, 32'h1);
   endtask

   task automatic t_count_write;
      logic [31:0] v;
      wr(A_CTL, 32'h3);
      wr(A_CNT, 32'd2);
      rd(A_CNT, v); chk("R5 count load replaces increment", v, 32'd2);
      repeat (2) @(negedge clk);
      rd(A_CNT, v); chk("R5 counts on from load", v, 32'd4);
      chk("R5 no expiry yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R3 expiry after load", {31'b0, irq_o}, 32'h1);
   endtask

   task automatic t_halt;
      logic [31:0] c0, v;
      wr(A_CTL, 32'h3);
      rd(A_CNT, c0);
      halt_i = 1'b1;
      repeat (3) @(negedge clk);
      rd(A_CNT, v); chk("R6 halted count holds", v, c0);
      wr(A_CTL, 32'h1);
      rd(A_CNT, v); chk("R6 hold on gate-off edge", v, c0);
      repeat (3) @(negedge clk);
      rd(A_CNT, v); chk("R6 halt ignored when ungated", v, c0 + 32'd3);
      halt_i = 1'b0;
   endtask

   task automatic t_mask_and_zero;
      logic [31:0] v;
      wr(A_CTL, 32'h2);
      wr(A_LIM, 32'd1);
      repeat (2) @(negedge clk);
      rd(A_CTL, v); chk("R9 flag sets while masked", v, 32'hA);
      chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
      wr(A_CTL, 32'hB);
      chk("R9 irq on enable", {31'b0, irq_o}, 32'h1);
      wr(A_LIM, 32'd8);
      wr(A_CTL, 32'h0);
      rd(A_CTL, v); chk("R11 control zero", v, 32'h0);
      chk("R11 irq low", {31'b0, irq_o}, 32'h0);
      repeat (8) @(negedge clk);
      rd(A_CTL, v); chk("R11 later expiry flag", v, 32'h8);
      chk("R11 later expiry no irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_wdog;
      logic [31:0] v;
      wr(A_CTL, 32'h7);
      wr(A_LIM, 32'd2);
      repeat (2) @(negedge clk);
      chk("R10 wdt low before expiry", {31'b0, wdt_rst_o}, 32'h0);
      @(negedge clk);
      chk("R10 wdt on expiry", {31'b0, wdt_rst_o}, 32'h1);
      rd(A_CTL, v); chk("R10 flag with wdt", v, 32'hF);
      @(negedge clk);
      chk("R10 wdt one cycle", {31'b0, wdt_rst_o}, 32'h0);
   endtask

   initial begin
      t_reset;
      t_regmap;
      t_period;
      t_flag_writes;
      t_race;
      t_count_write;
      t_halt;
      t_mask_and_zero;
      t_wdog;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule